// File: doc/BRIEF.md
# Video Field Sync Decoder and Blanker

This block sits behind a digital video input that carries interleaved 4:2:2 samples at 27 MHz and takes its timing from separate active-low horizontal and vertical sync lines. It registers both sync lines and looks for their falling edges. The relative timing of those two edges tells it where a new field begins and whether that field is odd or even. From there it tracks the pixel position inside the current line, the line position inside the frame, and which colour component (Cb, Y or Cr) occupies each clock.

A blank output follows one of two sources. When the external blank input is enabled, the output follows that input. When it is disabled, the block blanks on its own: the horizontal interval after each line sync, and the vertical-interval lines at the top of each field. One input selects between 525-line and 625-line timing. A 3-bit timing mode field enables decoding only for the code 101. Any other code holds the block in its idle state.

Top module: `fsd_top`

## Requirements
- R1: While reset is applied, field_valid is 0, blank_o is 1, and pix_cnt and line_cnt are 0.
- R2: A falling edge on hsync_n and a falling edge on vsync_n detected on the same clock start an odd field: field_odd becomes 1, line_cnt becomes 1, and pix_cnt becomes 0.
- R3: A falling edge on vsync_n detected while hsync_n is registered high starts an even field: field_odd becomes 0 and line_cnt becomes 264 (525-line) or 314 (625-line).
- R4: A falling edge on vsync_n while hsync_n is already registered low, with no hsync_n edge on that clock, starts no field and leaves field_odd unchanged.
- R5: pix_cnt advances by one every two clocks and returns to 0 on each hsync_n falling edge. Without such an edge it wraps from 857 to 0 (525-line) or from 863 to 0 (625-line).
- R6: Once a field has started, each hsync_n falling edge advances line_cnt by one. After line 525 (525-line) or line 625 (625-line) it wraps to 1.
- R7: comp repeats the code order 0, 1, 2, 1 (0 = Cb, 1 = Y, 2 = Cr) one step per clock. The order restarts at 0 on each hsync_n falling edge and on an odd field start, and the code 3 never appears.
- R8: With ext_blank_en = 0 and a field started, blank_o is 1 while pix_cnt is below 122 (525-line) or 132 (625-line).
- R9: With ext_blank_en = 0 and a field started, blank_o is 1 on frame lines 1..21 and 264..284 (525-line) or 1..23 and 314..336 (625-line). With pix_cnt past the horizontal interval, it is 0 on all other lines.
- R10: With ext_blank_en = 1 and a field started, blank_o equals the inverse of blank_n as registered on the previous clock edge.
- R11: While tmode is not 3'b101, field_valid is 0 and both counters are 0 on the following clock. Sync edges then start no field.
- R12: Before the first field start, hsync_n edges leave pix_cnt and line_cnt at 0, and blank_o stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| blank_n | input | 1 | External blank, active low |
| ext_blank_en | input | 1 | 1: blank_o follows blank_n; 0: automatic blanking |
| std625 | input | 1 | 0: 525-line timing; 1: 625-line timing |
| tmode | input | 3 | Timing mode field; decoding runs only at 3'b101 |
| field_valid | output | 1 | A field start has been seen since reset or mode entry |
| field_odd | output | 1 | 1: current field is odd; 0: even |
| pix_cnt | output | 10 | Pixel period within the line |
| line_cnt | output | 10 | Line within the frame, starting at 1 |
| comp | output | 2 | Component on this clock: 0 Cb, 1 Y, 2 Cr |
| blank_o | output | 1 | Blank output, active high |

## Verification
The bench builds the block with its default parameters: line lengths of 858 and 864 pixel periods, frames of 525 and 625 lines, horizontal intervals of 122 and 132, and vertical intervals of 21 and 23 lines. Most lines are driven very short, with hsync edges a few tens of clocks apart. That brings line 525 and line 625 and both frame wraps within reach. A few long lines carry pix_cnt past the horizontal interval and through the pixel wrap. Randomised sync patterns cover near-coincident edges, vsync edges while hsync is held low, and external blank toggling. A per-clock reference model covers each of these cases.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  // Timing mode code that enables sync decoding.
  localparam logic [2:0] MODE_DECODE = 3'b101;

  typedef enum logic [1:0] {
    COMP_CB = 2'd0,
    COMP_Y  = 2'd1,
    COMP_CR = 2'd2
  } comp_e;

  // Map the 4-step sample phase (Cb, Y, Cr, Y) onto a component code.
  function automatic comp_e phase_to_comp(input logic [1:0] ph);
    case (ph)
      2'd0:    phase_to_comp = COMP_CB;
      2'd2:    phase_to_comp = COMP_CR;
      default: phase_to_comp = COMP_Y;
    endcase
  endfunction

endpackage

// File: rtl/fsd_rst_sync.sv
module fsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = chain_q[STAGES-1];

endmodule

// File: rtl/fsd_edge.sv
module fsd_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall
);

  logic [N-1:0] cur_q;
  logic [N-1:0] prv_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[i] <= 1'b1;
        prv_q[i] <= 1'b1;
      end else begin
        cur_q[i] <= sig_n[i];
        prv_q[i] <= cur_q[i];
      end
    end
    assign fall[i] = prv_q[i] & ~cur_q[i];
  end

  assign lvl = cur_q;

endmodule

// File: rtl/fsd_timing.sv
module fsd_timing #(
  parameter int PIX_W    = 10,
  parameter int LINE_W   = 10,
  parameter int PIX525   = 858,
  parameter int PIX625   = 864,
  parameter int LINES525 = 525,
  parameter int LINES625 = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_on,
  input  logic              std625,
  input  logic              hs_lvl,
  input  logic              hs_fall,
  input  logic              vs_fall,
  output logic              valid,
  output logic              odd,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line,
  output logic [1:0]        phase
);

  localparam logic [PIX_W-1:0]  PLAST5 = PIX_W'(PIX525 - 1);
  localparam logic [PIX_W-1:0]  PLAST6 = PIX_W'(PIX625 - 1);
  localparam logic [LINE_W-1:0] LMAX5  = LINE_W'(LINES525);
  localparam logic [LINE_W-1:0] LMAX6  = LINE_W'(LINES625);
  localparam logic [LINE_W-1:0] LEVEN5 = LINE_W'((LINES525 + 1) / 2 + 1);
  localparam logic [LINE_W-1:0] LEVEN6 = LINE_W'((LINES625 + 1) / 2 + 1);
  localparam logic [LINE_W-1:0] LONE   = LINE_W'(1);

  logic              valid_q, valid_d;
  logic              odd_q, odd_d;
  logic [PIX_W-1:0]  pix_q, pix_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [1:0]        ph_q, ph_d;
  logic              upd_en;

  logic [PIX_W-1:0]  pix_last;
  logic [LINE_W-1:0] line_max;
  logic [LINE_W-1:0] line_even;
  logic              odd_start;
  logic              even_start;

  always_comb begin
    pix_last   = std625 ? PLAST6 : PLAST5;
    line_max   = std625 ? LMAX6  : LMAX5;
    line_even  = std625 ? LEVEN6 : LEVEN5;
    odd_start  = vs_fall & hs_fall;
    even_start = vs_fall & hs_lvl;

    valid_d = valid_q;
    odd_d   = odd_q;
    pix_d   = pix_q;
    line_d  = line_q;
    ph_d    = ph_q;

    if (!mode_on) begin
      valid_d = 1'b0;
      odd_d   = 1'b0;
      pix_d   = '0;
      line_d  = '0;
      ph_d    = '0;
    end else if (odd_start) begin
      valid_d = 1'b1;
      odd_d   = 1'b1;
      pix_d   = '0;
      line_d  = LONE;
      ph_d    = '0;
    end else begin
      if (even_start) begin
        valid_d = 1'b1;
        odd_d   = 1'b0;
        line_d  = line_even;
      end
      if (valid_q || even_start) begin
        if (hs_fall) begin
          pix_d  = '0;
          ph_d   = '0;
          line_d = (line_q >= line_max) ? LONE : line_q + LONE;
        end else begin
          ph_d = ph_q + 2'd1;
          if (ph_q[0]) begin
            pix_d = (pix_q >= pix_last) ? '0 : pix_q + PIX_W'(1);
          end
        end
      end
    end
  end

  // Registers only move while decoding or while leaving a valid state.
  assign upd_en = mode_on | valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      odd_q   <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
      ph_q    <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      odd_q   <= odd_d;
      pix_q   <= pix_d;
      line_q  <= line_d;
      ph_q    <= ph_d;
    end
  end

  assign valid = valid_q;
  assign odd   = odd_q;
  assign pix   = pix_q;
  assign line  = line_q;
  assign phase = ph_q;

endmodule

// File: rtl/fsd_blank.sv
module fsd_blank #(
  parameter int PIX_W    = 10,
  parameter int LINE_W   = 10,
  parameter int HBL525   = 122,
  parameter int HBL625   = 132,
  parameter int VBL525   = 21,
  parameter int VBL625   = 23,
  parameter int LINES525 = 525,
  parameter int LINES625 = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_n,
  input  logic              ext_en,
  input  logic              std625,
  input  logic              valid,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  output logic              blank
);

  localparam logic [PIX_W-1:0]  HB5  = PIX_W'(HBL525);
  localparam logic [PIX_W-1:0]  HB6  = PIX_W'(HBL625);
  localparam logic [LINE_W-1:0] VB5  = LINE_W'(VBL525);
  localparam logic [LINE_W-1:0] VB6  = LINE_W'(VBL625);
  localparam logic [LINE_W-1:0] F2S5 = LINE_W'((LINES525 + 1) / 2 + 1);
  localparam logic [LINE_W-1:0] F2S6 = LINE_W'((LINES625 + 1) / 2 + 1);
  localparam logic [LINE_W-1:0] F2E5 = LINE_W'((LINES525 + 1) / 2 + VBL525);
  localparam logic [LINE_W-1:0] F2E6 = LINE_W'((LINES625 + 1) / 2 + VBL625);

  logic              ext_q;
  logic [PIX_W-1:0]  hb_lim;
  logic [LINE_W-1:0] vb_end1, vb_beg2, vb_end2;
  logic              h_blank, v_blank, auto_blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b1;
    end else begin
      ext_q <= blank_n;
    end
  end

  always_comb begin
    hb_lim     = std625 ? HB6  : HB5;
    vb_end1    = std625 ? VB6  : VB5;
    vb_beg2    = std625 ? F2S6 : F2S5;
    vb_end2    = std625 ? F2E6 : F2E5;
    h_blank    = pix < hb_lim;
    v_blank    = ((line != '0) && (line <= vb_end1)) ||
                 ((line >= vb_beg2) && (line <= vb_end2));
    auto_blank = h_blank | v_blank;
    blank      = ~valid | (ext_en ? ~ext_q : auto_blank);
  end

endmodule

// File: rtl/fsd_top.sv
module fsd_top
  import fsd_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int LINE_W   = 10,
  parameter int PIX525   = 858,
  parameter int PIX625   = 864,
  parameter int LINES525 = 525,
  parameter int LINES625 = 625,
  parameter int HBL525   = 122,
  parameter int HBL625   = 132,
  parameter int VBL525   = 21,
  parameter int VBL625   = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_n,
  input  logic              vsync_n,
  input  logic              blank_n,
  input  logic              ext_blank_en,
  input  logic              std625,
  input  logic [2:0]        tmode,
  output logic              field_valid,
  output logic              field_odd,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic [1:0]        comp,
  output logic              blank_o
);

  logic       rst_s_n;
  logic [1:0] sync_lvl;
  logic [1:0] sync_fall;
  logic [1:0] phase;
  logic       mode_on;

  assign mode_on = (tmode == MODE_DECODE);

  fsd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // Bit 0: horizontal sync, bit 1: vertical sync.
  fsd_edge #(.N(2)) i_edge (
    .clk   (clk),
    .rst_n (rst_s_n),
    .sig_n ({vsync_n, hsync_n}),
    .lvl   (sync_lvl),
    .fall  (sync_fall)
  );

  fsd_timing #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .PIX525(PIX525), .PIX625(PIX625),
    .LINES525(LINES525), .LINES625(LINES625)
  ) i_timing (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .mode_on (mode_on),
    .std625  (std625),
    .hs_lvl  (sync_lvl[0]),
    .hs_fall (sync_fall[0]),
    .vs_fall (sync_fall[1]),
    .valid   (field_valid),
    .odd     (field_odd),
    .pix     (pix_cnt),
    .line    (line_cnt),
    .phase   (phase)
  );

  fsd_blank #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .HBL525(HBL525), .HBL625(HBL625),
    .VBL525(VBL525), .VBL625(VBL625), .LINES525(LINES525), .LINES625(LINES625)
  ) i_blank (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .blank_n (blank_n),
    .ext_en  (ext_blank_en),
    .std625  (std625),
    .valid   (field_valid),
    .pix     (pix_cnt),
    .line    (line_cnt),
    .blank   (blank_o)
  );

  assign comp = phase_to_comp(phase);

endmodule

// File: rtl/fsd_chk.sv
module fsd_chk #(
  parameter int PIX_W    = 10,
  parameter int LINE_W   = 10,
  parameter int PIX525   = 858,
  parameter int PIX625   = 864,
  parameter int LINES525 = 525,
  parameter int LINES625 = 625
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        tmode,
  input logic              std625,
  input logic              field_valid,
  input logic              field_odd,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic [1:0]        comp,
  input logic              blank_o
);

  localparam logic [PIX_W-1:0]  PL5 = PIX_W'(PIX525 - 1);
  localparam logic [PIX_W-1:0]  PL6 = PIX_W'(PIX625 - 1);
  localparam logic [LINE_W-1:0] LM5 = LINE_W'(LINES525);
  localparam logic [LINE_W-1:0] LM6 = LINE_W'(LINES625);
  localparam logic [LINE_W-1:0] LE5 = LINE_W'((LINES525 + 1) / 2 + 1);
  localparam logic [LINE_W-1:0] LE6 = LINE_W'((LINES625 + 1) / 2 + 1);

  logic [PIX_W-1:0]  plast;
  logic [LINE_W-1:0] lmax, leven;

  assign plast = std625 ? PL6 : PL5;
  assign lmax  = std625 ? LM6 : LM5;
  assign leven = std625 ? LE6 : LE5;

  // R5
  pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_cnt <= plast);

  // R6
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_valid |-> (line_cnt >= LINE_W'(1)) && (line_cnt <= lmax));

  // R7
  comp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp != 2'd3);

  // R7
  pix_step_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_valid && $past(field_valid) && (pix_cnt != $past(pix_cnt))) |-> (comp != 2'd1));

  // R11
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode != 3'b101) |=> !field_valid);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_valid |-> (pix_cnt == '0) && (line_cnt == '0) && blank_o);

  // R2
  odd_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_odd) |-> (line_cnt == LINE_W'(1)) && field_valid);

  // R3
  even_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_valid && $fell(field_odd)) |-> (line_cnt == leven));

endmodule

bind fsd_top fsd_chk #(
  .PIX_W(PIX_W), .LINE_W(LINE_W), .PIX525(PIX525), .PIX625(PIX625),
  .LINES525(LINES525), .LINES625(LINES625)
) i_fsd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tmode       (tmode),
  .std625      (std625),
  .field_valid (field_valid),
  .field_odd   (field_odd),
  .pix_cnt     (pix_cnt),
  .line_cnt    (line_cnt),
  .comp        (comp),
  .blank_o     (blank_o)
);

// File: tb/test_fsd_top.sv
`timescale 1ns/1ps
module test_fsd_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync_n, vsync_n, blank_n, ext_blank_en, std625;
  logic [2:0] tmode;
  logic       field_valid, field_odd, blank_o;
  logic [9:0] pix_cnt, line_cnt;
  logic [1:0] comp;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fsd_top i_fsd_top (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank_n(blank_n), .ext_blank_en(ext_blank_en), .std625(std625),
    .tmode(tmode), .field_valid(field_valid), .field_odd(field_odd),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .comp(comp), .blank_o(blank_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // ---------------- reference model built from the requirements ----------
  function automatic int pix_len(input bit s); return s ? 864 : 858; endfunction
  function automatic int frame_lines(input bit s); return s ? 625 : 525; endfunction
  function automatic int hblank(input bit s); return s ? 132 : 122; endfunction
  function automatic int vblank_n(input bit s); return s ? 23 : 21; endfunction
  function automatic int even_first(input bit s); return s ? 314 : 264; endfunction

  function automatic bit in_vblank(input int ln, input bit s);
    return (ln >= 1 && ln <= vblank_n(s)) ||
           (ln >= even_first(s) && ln < even_first(s) + vblank_n(s));
  endfunction

  function automatic int comp_of(input int ph);
    return (ph == 0) ? 0 : (ph == 2) ? 2 : 1;
  endfunction

  // Input values as sampled at the last three rising edges.
  bit h1 = 1, h2 = 1, h3 = 1, v1 = 1, v2 = 1, v3 = 1, b1 = 1, s1 = 0;
  logic [2:0] m1 = 3'b101;
  int rcnt = 0;

  always @(posedge clk) begin
    h3 <= h2; h2 <= h1; h1 <= hsync_n;
    v3 <= v2; v2 <= v1; v1 <= vsync_n;
    b1 <= blank_n; s1 <= std625; m1 <= tmode;
    if (!rst_n) rcnt <= 0;
    else if (rcnt < 3) rcnt <= rcnt + 1;
  end

  bit m_valid, m_odd;
  int m_pix, m_line, m_ph;
  bit model_on = 0;

  always @(negedge clk) begin
    bit hf, vf, exp_blank;
    if (!rst_n || rcnt < 3) begin
      m_valid = 0; m_odd = 0; m_pix = 0; m_line = 0; m_ph = 0;
    end else begin
      hf = h3 & ~h2;
      vf = v3 & ~v2;
      if (m1 != 3'b101) begin
        m_valid = 0; m_odd = 0; m_pix = 0; m_line = 0; m_ph = 0;
      end else if (hf && vf) begin
        m_valid = 1; m_odd = 1; m_pix = 0; m_line = 1; m_ph = 0;
      end else begin
        bit ev;
        ev = vf && h2;
        if (ev) begin m_valid = 1; m_odd = 0; m_line = even_first(s1); end
        if (m_valid) begin
          if (hf && !ev) begin
            m_pix = 0; m_ph = 0;
            m_line = (m_line >= frame_lines(s1)) ? 1 : m_line + 1;
          end else begin
            if (m_ph % 2 == 1) m_pix = (m_pix >= pix_len(s1) - 1) ? 0 : m_pix + 1;
            m_ph = (m_ph + 1) % 4;
          end
        end
      end
    end
    if (model_on) begin
      exp_blank = !m_valid || (ext_blank_en ? !b1
                  : (m_pix < hblank(std625) || in_vblank(m_line, std625)));
      chk("R2 R3 field_valid", field_valid, m_valid);
      chk("R2 R3 R4 field_odd", field_odd, m_odd);
      chk("R5 pix_cnt", pix_cnt, m_pix);
      chk("R6 line_cnt", line_cnt, m_line);
      chk("R7 comp", comp, comp_of(m_ph));
      chk("R8 R9 R10 blank_o", blank_o, exp_blank);
    end
  end

  // ---------------- stimulus ----------------------------------------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hpulse(input int total, input int low);
    hsync_n = 0; tick(low);
    hsync_n = 1; tick(total - low);
  endtask

  task automatic odd_start(input int total);
    hsync_n = 0; vsync_n = 0; tick(4);
    hsync_n = 1; tick(total - 4);
    vsync_n = 1;
  endtask

  task automatic even_start(input int total);
    hsync_n = 0; tick(4);
    hsync_n = 1; tick(total / 2);
    vsync_n = 0; tick(total - total / 2 - 4);
    vsync_n = 1;
  endtask

  task automatic run_standard(input bit s);
    std625 = s; tick(4);
    odd_start(40);
    chk("R2 odd flag", field_odd, 1);
    chk("R2 odd line", line_cnt, 1);
    for (int i = 0; i < vblank_n(s) - 2; i++) hpulse(40, 4);
    hpulse(300, 4);
    chk("R9 last vertical line", line_cnt, vblank_n(s));
    chk("R9 blank on last vertical line", blank_o, 1);
    hpulse(300, 4);
    chk("R5 pix after 298 clocks", pix_cnt, 149);
    chk("R8 R9 active pixel unblanked", blank_o, 0);
    for (int i = 0; i < frame_lines(s) - vblank_n(s) - 1; i++) hpulse(40, 4);
    chk("R6 last frame line", line_cnt, frame_lines(s));
    hpulse(40, 4);
    chk("R6 frame wrap", line_cnt, 1);
    even_start(40);
    chk("R3 even flag", field_odd, 0);
    chk("R3 even line", line_cnt, even_first(s));
    // vsync falls one clock after hsync, with hsync held low.
    hsync_n = 0; tick(1);
    vsync_n = 0; tick(3);
    hsync_n = 1; tick(36);
    vsync_n = 1;
    chk("R4 field flag kept", field_odd, 0);
    chk("R4 line advanced once", line_cnt, even_first(s) + 1);
    hpulse(2 * pix_len(s) + 40, 4);
    chk("R5 pix wrap", pix_cnt, 19);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd2024);
    rst_n = 0; hsync_n = 1; vsync_n = 1; blank_n = 1;
    ext_blank_en = 0; std625 = 0; tmode = 3'b101;
    model_on = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", field_valid, 0);
    chk("R1 reset blank", blank_o, 1);
    chk("R1 reset pix", pix_cnt, 0);
    chk("R1 reset line", line_cnt, 0);
    @(posedge clk); #2;
    rst_n = 1;
    tick(6);

    hpulse(40, 4); hpulse(40, 4);
    chk("R12 pix idle", pix_cnt, 0);
    chk("R12 line idle", line_cnt, 0);
    chk("R12 blank idle", blank_o, 1);

    run_standard(0);

    ext_blank_en = 1;
    blank_n = 0; tick(1);
    chk("R10 ext blank low", blank_o, 1);
    blank_n = 1; tick(1);
    chk("R10 ext blank high", blank_o, 0);
    ext_blank_en = 0;

    tmode = 3'b100; tick(2);
    chk("R11 mode off valid", field_valid, 0);
    chk("R11 mode off line", line_cnt, 0);
    odd_start(40);
    chk("R11 no start when off", field_valid, 0);
    tmode = 3'b101; tick(2);
    chk("R12 no field yet", field_valid, 0);

    run_standard(1);

    // Constrained random phase.
    for (int k = 0; k < 320; k++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (sel < 6) odd_start(int'($urandom_range(20, 300)));
      else if (sel < 12) even_start(int'($urandom_range(20, 300)));
      else if (sel < 18) begin
        hsync_n = 0; tick(int'($urandom_range(1, 3)));
        vsync_n = 0; tick(3); hsync_n = 1; tick(20); vsync_n = 1;
      end else if (sel < 24) begin
        vsync_n = 0; tick(1); hsync_n = 0; tick(4);
        hsync_n = 1; vsync_n = 1; tick(30);
      end else if (sel < 32) begin
        ext_blank_en = $urandom_range(0, 1) == 1;
        blank_n = $urandom_range(0, 1) == 1;
        tick(int'($urandom_range(1, 10)));
      end else if (sel < 34) begin
        tmode = 3'($urandom_range(0, 7)); tick(3); tmode = 3'b101;
      end else if (sel < 36) begin
        std625 = ~std625; tick(2);
      end else hpulse(int'($urandom_range(10, 400)), int'($urandom_range(1, 8)));
    end
    tick(4);
    report();
  end

  initial begin
    #(10 * 195000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

endmodule